// File: doc/BRIEF.md
# SMM Memory Window Control and Routing

This block keeps the control byte for the system-management memory window and decides, on every processor access that falls inside that window, whether the access is sent to DRAM or left on the PCI bus. The window address compare and the memory and bus cycles themselves sit outside the block. The block only holds the control state and produces a DRAM-select decision for the access that is currently presented.

Software writes the control byte through a byte-wide configuration strobe. On each write the block keeps four control bits: window open, window closed, lock and enable. It forces the other bits to fixed values. The lock bit is handled by a two-state machine. In state `LK_FREE` a write may set lock, which takes the transition `seal` into `LK_SEALED`. From `LK_SEALED` there is no transition back except the power-on reset. While sealed, every write clears the open bit, so both open and lock become read-only.

The routing decision is combinational from the stored fields, the processor SMM indication and the access type. The result is one of four route classes: `RT_PCI`, `RT_DRAM_ALL`, `RT_CODE_ONLY` and `RT_BLOCKED`. A registered error flag reports that a write committed open and closed together. The flag keeps its value until the next write.

Top module: `smm_window_ctl`

## Requirements
- R1: After power-on reset (`por_n` low) the readback is 0x02, `to_dram` is 0 for every input combination, and `cfg_err` is 0.
- R2: A write (`cfg_wr` high at a clock edge) stores data bits 6 (open), 5 (closed), 4 (lock) and 3 (enable). Readback bit 7 reads 0 and readback bits 2:0 read 010 whatever was written. The new value is visible from that edge onward.
- R3: Once lock (bit 4) reads 1, every later write leaves lock at 1 and stores open (bit 6) as 0. Closed and enable still take the written data.
- R4: Only a power-on reset clears lock. After reset the readback is 0x02 again.
- R5: With enable (bit 3) clear, `to_dram` is 0 for code and data, in and out of SMM.
- R6: Enabled, unlocked, open clear and `cpu_smm` low: `to_dram` is 0.
- R7: Enabled, unlocked, open set and closed clear: `to_dram` is 1 for code and data, whatever `cpu_smm` is.
- R8: Enabled, `cpu_smm` high and closed clear, with open clear or lock set: `to_dram` is 1 for code and data.
- R9: Enabled, `cpu_smm` high and closed set, with open clear or lock set: `to_dram` equals `acc_is_code` (1 = code fetch), so code goes to DRAM and data goes to PCI.
- R10: Enabled and locked with `cpu_smm` low: `to_dram` is 0, even when the open bit reads 1.
- R11: A write that leaves open and closed both set raises `cfg_err` from that edge. The flag holds until the next write, which recomputes it. While unlocked in that state, `to_dram` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cpu_smm | input | 1 | Processor is in system-management mode |
| acc_is_code | input | 1 | Current access is a code fetch (1) or a data access (0) |
| ctl_rdata | output | 8 | Control byte readback |
| to_dram | output | 1 | 1 routes the current window access to DRAM, 0 to PCI |
| cfg_err | output | 1 | Open and closed were committed together |

## Verification
Readback and the error flag come from registers, so each is due on the first clock edge that samples the write. The bench drives inputs on the falling edge and checks just after the following rising edge. `to_dram` is combinational, so it is due in the same cycle as any change to `cpu_smm` or `acc_is_code`. The bench therefore changes `acc_is_code` after the edge and checks after a short settle delay, covering both access types against the value that was just committed.

// File: rtl/smm_ctl_pkg.sv
package smm_ctl_pkg;
    localparam int CTL_W      = 8;
    localparam int OPEN_BIT   = 6;
    localparam int CLOSED_BIT = 5;
    localparam int LOCK_BIT   = 4;
    localparam int EN_BIT     = 3;
    localparam int SEG_W      = 3;
    localparam logic [SEG_W-1:0] SEG_FIXED = 3'b010;

    typedef enum logic {
        LK_FREE,
        LK_SEALED
    } lock_state_e;

    typedef enum logic [1:0] {
        RT_PCI,
        RT_DRAM_ALL,
        RT_CODE_ONLY,
        RT_BLOCKED
    } route_cls_e;

    typedef struct packed {
        logic open;
        logic closed;
        logic enable;
    } ctl_fields_t;
endpackage

// File: rtl/smm_ctl_reg.sv
module smm_ctl_reg
    import smm_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output ctl_fields_t      fields,
    output logic             locked
);
    lock_state_e state_q, state_d;
    ctl_fields_t fld_q;

    // lock state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= LK_FREE;
        else        state_q <= state_d;
    end

    // lock next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_FREE:   if (wr_en && wr_data[LOCK_BIT]) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
        endcase
    end

    // field storage; open is forced low once sealed
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fld_q <= '0;
        end else if (wr_en) begin
            fld_q.open   <= wr_data[OPEN_BIT] & (state_q == LK_FREE);
            fld_q.closed <= wr_data[CLOSED_BIT];
            fld_q.enable <= wr_data[EN_BIT];
        end
    end

    always_comb begin
        fields = fld_q;
        locked = (state_q == LK_SEALED);
    end

    assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!por_n)
        locked |=> locked);
    assert_sealed_write_closes_R3: assert property (@(posedge clk) disable iff (!por_n)
        (wr_en && locked) |=> !fields.open);
endmodule

// File: rtl/smm_route.sv
module smm_route
    import smm_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        por_n,
    input  ctl_fields_t fields,
    input  logic        locked,
    input  logic        smm,
    input  logic        is_code,
    output logic        to_dram
);
    route_cls_e cls;

    always_comb begin
        if (!fields.enable)                                   cls = RT_PCI;
        else if (!locked && fields.open && fields.closed)     cls = RT_BLOCKED;
        else if (!locked && fields.open)                      cls = RT_DRAM_ALL;
        else if (smm && !fields.closed)                       cls = RT_DRAM_ALL;
        else if (smm)                                         cls = RT_CODE_ONLY;
        else                                                  cls = RT_PCI;
    end

    always_comb begin
        unique case (cls)
            RT_PCI:       to_dram = 1'b0;
            RT_DRAM_ALL:  to_dram = 1'b1;
            RT_CODE_ONLY: to_dram = is_code;
            RT_BLOCKED:   to_dram = 1'b0;
        endcase
    end

    assert_disabled_pci_R5: assert property (@(posedge clk) disable iff (!por_n)
        !fields.enable |-> !to_dram);
    assert_data_stays_pci_R9: assert property (@(posedge clk) disable iff (!por_n)
        (fields.closed && !is_code && (locked || !fields.open)) |-> !to_dram);
endmodule

// File: rtl/smm_cfg_err.sv
module smm_cfg_err
    import smm_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             locked,
    output logic             err
);
    logic err_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)     err_q <= 1'b0;
        else if (wr_en) err_q <= wr_data[OPEN_BIT] & wr_data[CLOSED_BIT] & !locked;
    end

    assign err = err_q;

    assert_err_holds_R11: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> $stable(err));
endmodule

// File: rtl/smm_window_ctl.sv
module smm_window_ctl
    import smm_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             cfg_wr,
    input  logic [CTL_W-1:0] cfg_wdata,
    input  logic             cpu_smm,
    input  logic             acc_is_code,
    output logic [CTL_W-1:0] ctl_rdata,
    output logic             to_dram,
    output logic             cfg_err
);
    ctl_fields_t fields;
    logic        locked;

    smm_ctl_reg u_reg (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .fields  (fields),
        .locked  (locked)
    );

    smm_route u_route (
        .clk     (clk),
        .por_n   (por_n),
        .fields  (fields),
        .locked  (locked),
        .smm     (cpu_smm),
        .is_code (acc_is_code),
        .to_dram (to_dram)
    );

    smm_cfg_err u_err (
        .clk     (clk),
        .por_n   (por_n),
        .wr_en   (cfg_wr),
        .wr_data (cfg_wdata),
        .locked  (locked),
        .err     (cfg_err)
    );

    always_comb begin
        ctl_rdata             = '0;
        ctl_rdata[SEG_W-1:0]  = SEG_FIXED;
        ctl_rdata[EN_BIT]     = fields.enable;
        ctl_rdata[LOCK_BIT]   = locked;
        ctl_rdata[CLOSED_BIT] = fields.closed;
        ctl_rdata[OPEN_BIT]   = fields.open;
    end

    assert_locked_outside_pci_R10: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_rdata[LOCK_BIT] && !cpu_smm) |-> !to_dram);
    assert_open_dram_R7: assert property (@(posedge clk) disable iff (!por_n)
        (ctl_rdata[7:3] == 5'b01001) |-> to_dram);
endmodule

// File: tb/sim_smm_window_ctl.sv
module sim_smm_window_ctl;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       cpu_smm = 1'b0;
    logic       acc_is_code = 1'b0;
    logic [7:0] ctl_rdata;
    logic       to_dram;
    logic       cfg_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_reg = 8'h02;
    logic       m_err = 1'b0;

    always #5 clk = ~clk;

    smm_window_ctl u0 (
        .clk(clk), .por_n(por_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cpu_smm(cpu_smm), .acc_is_code(acc_is_code),
        .ctl_rdata(ctl_rdata), .to_dram(to_dram), .cfg_err(cfg_err)
    );

    function automatic logic [7:0] f_commit(input logic [7:0] old, input logic [7:0] d);
        logic [7:0] n;
        n = {1'b0, d[6:3], 3'b010};
        if (old[4]) begin
            n[6] = 1'b0;
            n[4] = 1'b1;
        end
        return n;
    endfunction

    function automatic logic f_route(input logic [7:0] r, input logic smm, input logic code);
        if (!r[3])      return 1'b0;
        else if (r[4])  return smm & (!r[5] | code);
        else if (r[6])  return !r[5];
        else            return smm & (!r[5] | code);
    endfunction

    function automatic string f_tag(input logic [7:0] r, input logic smm);
        if (!r[3])               return "R5";
        else if (r[4] && !smm)   return "R10";
        else if (!r[4] && r[6] && r[5]) return "R11";
        else if (!r[4] && r[6])  return "R7";
        else if (!smm)           return "R6";
        else if (!r[5])          return "R8";
        else                     return "R9";
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " readback"}, ctl_rdata, m_reg);
        chk({tag, " err"}, {7'd0, cfg_err}, {7'd0, m_err});
        for (int c = 0; c < 2; c++) begin
            acc_is_code = c[0];
            #1;
            chk({tag, " route"}, {7'd0, to_dram}, {7'd0, f_route(m_reg, cpu_smm, c[0])});
        end
    endtask

    task automatic step(input logic wr, input logic [7:0] d, input logic smm, input string tag);
        @(negedge clk);
        cfg_wr = wr; cfg_wdata = d; cpu_smm = smm;
        @(posedge clk);
        if (wr) begin
            m_reg = f_commit(m_reg, d);
            m_err = m_reg[6] & m_reg[5];
        end
        #1;
        check_all(tag);
    endtask

    task automatic do_por();
        @(negedge clk);
        cfg_wr = 1'b0; por_n = 1'b0;
        m_reg = 8'h02; m_err = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            logic wr, smm;
            wr  = ($urandom % 3) == 0;
            d   = 8'($urandom);
            if (($urandom % 4) != 0) d[4] = 1'b0;
            smm = 1'($urandom);
            step(wr, d, smm, f_tag(f_commit(wr ? f_commit(m_reg, d) : m_reg, 8'h00) | (wr ? f_commit(m_reg, d) : m_reg), smm));
        end
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        cpu_smm = 1'b0;
        #1;
        check_all("R1 reset");
        cpu_smm = 1'b1;
        check_all("R1 reset smm");

        step(1'b1, 8'h85, 1'b0, "R2 fixed bits");
        step(1'b1, 8'h08, 1'b0, "R6");
        step(1'b0, 8'h00, 1'b1, "R8");
        step(1'b1, 8'h28, 1'b1, "R9");
        step(1'b1, 8'h48, 1'b0, "R7");
        step(1'b0, 8'h00, 1'b1, "R7 smm");
        step(1'b1, 8'h60, 1'b1, "R5");
        step(1'b1, 8'h68, 1'b1, "R11 set");
        step(1'b0, 8'h00, 1'b0, "R11 hold");
        step(1'b1, 8'h08, 1'b0, "R11 clear");
        step(1'b1, 8'h58, 1'b0, "R10 open read 1");
        step(1'b0, 8'h00, 1'b1, "R8 locked");
        step(1'b1, 8'h48, 1'b0, "R3 open forced");
        step(1'b1, 8'h00, 1'b0, "R3 lock kept");
        step(1'b1, 8'h68, 1'b1, "R3 closed writable");
        chk("R3 lock bit", {7'd0, ctl_rdata[4]}, 8'h01);

        rand_run(400);

        do_por();
        #1;
        check_all("R4 por clears lock");
        step(1'b1, 8'h48, 1'b0, "R4 open writable after por");

        rand_run(400);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule